// File: doc/BRIEF.md
# Six-Step Commutation Sequencer with Float Windows

This block produces the switching pattern for a three-phase bridge run in six-step commutation. A counter-compare timer sets the step rate from a period word. Each time the timer fires, a six-state sequencer moves one step. A decoder turns the current step into one level bit and one active-low float bit per phase. The controller above this block sets the period word, so that word decides the electrical frequency.

Two pattern sets are available. In plain mode each phase is driven high for three steps and low for three steps, and no phase is ever floated. In float mode each phase passes through a floated step between every high and low interval, so exactly one phase is off the bridge in every step. A direction input reverses rotation by exchanging the outputs of phases B and C. Phase A and the order of the steps stay the same.

The level bit of a floated phase carries no new information. It repeats the last value that phase drove, so the output bus only changes when a phase is actually driven. A period word of zero stops the sequence. The step strobe marks each advance so the controller can count steps.

Top module: `six_step_seq`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first strobe, the block is in step index 0. In that state `step_o` is 0, `level_o` is 3'b011 (bit 0 is phase A, bit 1 is phase B, bit 2 is phase C) and `float_no` is 3'b111 in plain mode.
- R2: With a nonzero period P held constant, `step_o` is high for exactly one cycle in every P+1 cycles. The first pulse is in the (P+1)th cycle after reset is released, and two pulses are never adjacent.
- R3: The step index goes up by one on the same clock edge that raises `step_o`, wrapping from 5 back to 0. It never changes without a strobe.
- R4: In plain mode with `dir_i`=0 (forward), the levels for step indices 0 to 5 are: phase A 1,1,1,0,0,0; phase B 1,0,0,0,1,1; phase C 0,0,1,1,1,0.
- R5: In float mode (`float_mode_i`=1) with forward direction, the patterns for steps 0 to 5 are: phase A H,H,F,L,L,F; phase B L,F,H,H,F,L; phase C F,L,L,F,H,H. H drives 1 and L drives 0. F drives the phase's `float_no` bit to 0, and that bit is 1 in every other step, so exactly one phase is floated at a time.
- R6: With `dir_i`=1 (reverse), in both modes, phase A is unchanged and the level and float patterns of phases B and C are exchanged. The step order is unchanged.
- R7: In plain mode all three `float_no` bits are 1.
- R8: While a phase is floated, its `level_o` bit holds the last value that phase drove. If that phase has not been driven since reset, the bit is 0.
- R9: When the period word is 0, `step_o` stays low, the step index is frozen and the counter is held clear. A later nonzero period P gives the first strobe P+1 cycles after it is applied.
- R10: If the period word drops to a value at or below the current count, the timer fires on the next clock edge, because the compare is greater-or-equal.
- R11: With the default 16-bit period word and a 125 MHz clock, a step rate of 2400 per second (400 Hz electrical) can be reached. This uses period 52082, which gives 52083 cycles per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Step period word; 0 stops the sequence |
| dir_i | input | 1 | 0 forward, 1 reverse (B and C exchanged) |
| float_mode_i | input | 1 | 0 plain six-step, 1 six-step with float windows |
| level_o | output | 3 | Per-phase high/low level, bit 0 = A |
| float_no | output | 3 | Per-phase float, active low |
| step_o | output | 1 | One-cycle strobe marking a step advance |

## Verification
The strobe-spacing and freeze assertions assume that `period_i`, `dir_i` and `float_mode_i` change only between clock edges and are never X or Z while reset is released. The level-hold assertion only looks at cycles that follow a released-reset cycle. It therefore does not depend on what the inputs did during reset. The stimulus drives every input on the falling edge. It changes the period, mode and direction only at those points, including the moments when the period falls below the running count and when it is set to zero.

// File: rtl/six_step_pkg.sv
package six_step_pkg;
  localparam int unsigned NUM_STEPS = 6;
  localparam int unsigned NUM_PH    = 3;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  typedef int unsigned uint_t;
  typedef logic [STEP_W-1:0] step_t;

  // modulo-six rotation of a step index
  function automatic step_t step_rot(step_t s, uint_t off);
    uint_t sum;
    sum = uint_t'(s) + (off % NUM_STEPS);
    if (sum >= NUM_STEPS) sum = sum - NUM_STEPS;
    return step_t'(sum);
  endfunction
endpackage

// File: rtl/six_step_timer.sv
module six_step_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run    = |period_i;
  assign tick_o = run && (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (tick_o || !run)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q) |-> tick_o);
  // R9
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/six_step_state.sv
module six_step_state
  import six_step_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  output step_t step_o,
  output logic  strobe_o
);
  step_t step_q;
  logic  strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= adv_i;
      if (adv_i) step_q <= step_rot(step_q, 1);
    end
  end

  assign step_o   = step_q;
  assign strobe_o = strobe_q;

  // R3
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q < STEP_W'(NUM_STEPS));
  // R3
  step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(step_q));
endmodule

// File: rtl/six_step_decode.sv
module six_step_decode
  import six_step_pkg::*;
(
  input  step_t             step_i,
  input  logic              float_mode_i,
  input  logic              dir_i,
  output logic [NUM_PH-1:0] drive_o,
  output logic [NUM_PH-1:0] float_no
);
  localparam int unsigned PLAIN_HI = NUM_STEPS / 2;  // steps high in plain mode
  localparam int unsigned FLT_HI   = PLAIN_HI - 1;   // steps high in float mode
  localparam int unsigned FLT_A    = FLT_HI;         // first float step
  localparam int unsigned FLT_B    = NUM_STEPS - 1;  // second float step

  logic [NUM_PH-1:0] pat_lvl, pat_flt;

  // per-pattern decode; phase q is phase A rotated by 2q (plain) or -2q (float)
  for (genvar q = 0; q < NUM_PH; q++) begin : g_pat
    localparam int unsigned OFF_PLAIN = (2 * q) % NUM_STEPS;
    localparam int unsigned OFF_FLT   = (NUM_STEPS - 2 * q) % NUM_STEPS;
    step_t kp, kf;
    assign kp = step_rot(step_i, OFF_PLAIN);
    assign kf = step_rot(step_i, OFF_FLT);
    assign pat_flt[q] = float_mode_i &&
                        ((kf == STEP_W'(FLT_A)) || (kf == STEP_W'(FLT_B)));
    assign pat_lvl[q] = float_mode_i ? (kf < STEP_W'(FLT_HI))
                                     : (kp < STEP_W'(PLAIN_HI));
  end

  // reverse swaps B and C; A maps to itself
  for (genvar p = 0; p < NUM_PH; p++) begin : g_out
    localparam int unsigned ALT = (p == 0) ? 0 : NUM_PH - p;
    assign drive_o[p]  = dir_i ? pat_lvl[ALT] : pat_lvl[p];
    assign float_no[p] = ~(dir_i ? pat_flt[ALT] : pat_flt[p]);
  end
endmodule

// File: rtl/six_step_seq.sv
module six_step_seq
  import six_step_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              dir_i,
  input  logic              float_mode_i,
  output logic [NUM_PH-1:0] level_o,
  output logic [NUM_PH-1:0] float_no,
  output logic              step_o
);
  logic              tick;
  step_t             step_idx;
  logic [NUM_PH-1:0] drive, held_q;

  six_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .tick_o  (tick)
  );

  six_step_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (tick),
    .step_o  (step_idx),
    .strobe_o(step_o)
  );

  six_step_decode u_decode (
    .step_i      (step_idx),
    .float_mode_i(float_mode_i),
    .dir_i       (dir_i),
    .drive_o     (drive),
    .float_no    (float_no)
  );

  // floated phases repeat their last driven level
  assign level_o = (float_no & drive) | (~float_no & held_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= level_o;
  end

  // R2
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
  // R9
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |=> !step_o);
  // R7
  plain_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !float_mode_i |-> (&float_no));
  // R5
  one_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_mode_i |-> ($countones(~float_no) == 1));

  for (genvar p = 0; p < NUM_PH; p++) begin : g_hold_chk
    // R8
    float_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!float_no[p] && $past(rst_ni)) |-> (level_o[p] == $past(level_o[p])));
  end
endmodule

// File: tb/six_step_seq_test.sv
module six_step_seq_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] period;
  logic             dir, fmode;
  logic [2:0]       lvl, fno;
  logic             stp;

  int checks = 0;
  int errors = 0;
  string ctx = "";

  int         m_cnt, m_state;
  logic [2:0] m_held;
  logic       m_step;

  always #4 clk = ~clk;

  six_step_seq #(.CNT_W(CNT_W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .period_i    (period),
    .dir_i       (dir),
    .float_mode_i(fmode),
    .level_o     (lvl),
    .float_no    (fno),
    .step_o      (stp)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  // expected outputs from the pattern rules (R4 R5 R6 R8)
  task automatic expect_out(input int s, input logic fm, input logic d,
                            input logic [2:0] held, output logic [2:0] el,
                            output logic [2:0] ef);
    for (int p = 0; p < 3; p++) begin
      int q, k;
      q = (d && p != 0) ? 3 - p : p;
      if (!fm) begin
        k = (s + 2 * q) % 6;
        el[p] = (k < 3);
        ef[p] = 1'b1;
      end else begin
        k = (s + (6 - 2 * q) % 6) % 6;
        if (k == 2 || k == 5) begin
          ef[p] = 1'b0;
          el[p] = held[p];
        end else begin
          ef[p] = 1'b1;
          el[p] = (k < 2);
        end
      end
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_state = 0; m_held = 3'b000; m_step = 1'b0;
  endtask

  task automatic model_edge();
    logic [2:0] el, ef;
    expect_out(m_state, fmode, dir, m_held, el, ef);
    m_held = el;
    if (period != 0 && m_cnt >= int'(period)) begin
      m_cnt = 0; m_state = (m_state + 1) % 6; m_step = 1'b1;
    end else begin
      m_cnt = (period == 0) ? 0 : m_cnt + 1; m_step = 1'b0;
    end
  endtask

  task automatic compare();
    logic [2:0] el, ef;
    string tag;
    expect_out(m_state, fmode, dir, m_held, el, ef);
    tag = dir ? "R3 R6" : (fmode ? "R3 R5" : "R3 R4");
    check(stp === m_step, "R2", 16'(stp), 16'(m_step));
    check(fno === ef, fmode ? tag : "R7", 16'(fno), 16'(ef));
    check((lvl & ef) === (el & ef), tag, 16'(lvl), 16'(el));
    check((lvl & ~ef) === (el & ~ef), "R8", 16'(lvl), 16'(el));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      model_edge();
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    ctx = "R1";
    compare();
    check(lvl === 3'b011 || fmode || dir, "R1", 16'(lvl), 16'h3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; period = 16'd3; dir = 1'b0; fmode = 1'b0;
    @(negedge clk);
    do_reset();
    ctx = "R2";
    run(3 * 4 + 2);

    // sweep modes, directions and short periods
    for (int fm = 0; fm < 2; fm++) begin
      for (int d = 0; d < 2; d++) begin
        for (int pp = 1; pp <= 3; pp++) begin
          fmode  = fm[0];
          dir    = d[0];
          period = 16'(pp);
          ctx = "sweep";
          run(12 * (pp + 1) + 3);
        end
      end
    end

    // R10: period dropped under the running count
    ctx = "R10"; fmode = 1'b1; dir = 1'b0; period = 16'd100;
    run(50);
    period = 16'd10;
    run(30);

    // R9: zero period freezes, restart timing
    ctx = "R9"; period = 16'd0;
    run(40);
    period = 16'd4;
    run(30);

    // R11: long period at full width
    fmode = 1'b1; dir = 1'b1; period = 16'd52082;
    do_reset();
    ctx = "R11";
    run(52090);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule